// File: doc/BRIEF.md
# Serial Basic Clock Generator

This block produces the one-cycle basic clock enable that paces a serial channel's shift and sample logic. It does not generate a real clock. It produces a single-system-clock strobe, and downstream logic uses that strobe as an enable.

In synchronous mode, the block does one of two things:
- It halves the rate of an incoming baud-rate tick and drives a shift clock out on a pin.
- It takes an external shift clock, synchronizes it and turns a chosen edge into a strobe.

In asynchronous (UART) mode, a 2-bit selector picks where the strobe comes from:
- the baud-rate tick,
- the peripheral clock, which gives a strobe on every cycle,
- a timer match pulse,
- the rising edge of the external clock pin.

Whenever a control input changes, the block suppresses the strobe for one cycle and restarts the halving stage. This keeps stale state from producing a pulse the new setting did not ask for.

Top module: `serial_baseclk_gen`

## Requirements
- R1: With `async_mode`=0 and `sclk_dir_in`=0, `base_en` pulses once for every two `baud_tick` pulses. The pulse comes from the second tick, the one that returns `sclk_out` high, and appears one cycle after that tick.
- R2: In synchronous output mode, `sclk_out` inverts one cycle after each `baud_tick`. `sclk_oe` is 1 only when `async_mode`=0 and `sclk_dir_in`=0.
- R3: With `async_mode`=0 and `sclk_dir_in`=1, a change on `sclk_in` produces a `base_en` pulse three cycles later. Only the selected edge counts: rising when `edge_fall`=0, falling when `edge_fall`=1. The other edge gives no pulse.
- R4: With `async_mode`=1 and `src_sel`=2'b00, each `baud_tick` gives a `base_en` pulse one cycle later.
- R5: With `async_mode`=1 and `src_sel`=2'b01, `base_en` is high on every cycle.
- R6: With `async_mode`=1 and `src_sel`=2'b10, each `timer_match` gives a `base_en` pulse one cycle later.
- R7: With `async_mode`=1 and `src_sel`=2'b11, a rising edge on `sclk_in` gives a `base_en` pulse three cycles later. A falling edge gives none.
- R8: During and after reset, `base_en` is 0 and `sclk_out` is 1. Whenever the block is not in synchronous output mode, `sclk_out` is 1 from the next cycle on.
- R9: In the cycle after any of `async_mode`, `sclk_dir_in`, `edge_fall` or `src_sel` changes, `base_en` is 0 even if the new or the old source fired. The halving stage also restarts with `sclk_out` high.
- R10: Sources that the current setting does not select never cause a `base_en` pulse, and a `baud_tick` outside synchronous output mode leaves `sclk_out` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| async_mode | input | 1 | 1 = UART mode, 0 = synchronous mode |
| sclk_dir_in | input | 1 | Synchronous mode: 1 = shift clock is an input, 0 = driven out |
| edge_fall | input | 1 | Synchronous input mode: 1 = falling edge, 0 = rising edge |
| src_sel | input | 2 | UART source: 00 baud tick, 01 peripheral clock, 10 timer match, 11 pin |
| baud_tick | input | 1 | One-cycle tick from the baud-rate generator |
| timer_match | input | 1 | One-cycle timer match pulse |
| sclk_in | input | 1 | External clock pin, asynchronous |
| base_en | output | 1 | One-cycle basic clock enable |
| sclk_out | output | 1 | Shift clock drive, idles high |
| sclk_oe | output | 1 | Shift clock output enable |

## Verification
The bench targets the parity of the halving stage. A design that strobed on the first tick, or did not restart after a mode change, would show its pulse one tick early. It also covers both edges in each pin mode, because swapping the edge polarity moves every pulse onto the wrong transition. A control change that lands in the same cycle as a live tick, and a switch away from the every-cycle source, expose a design that lets a stale strobe through. A design that pulsed on every baud tick in synchronous output mode would see its extra pulses flagged as unexpected.

// File: rtl/serial_baseclk_gen.sv
module serial_baseclk_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       async_mode,
  input  logic       sclk_dir_in,
  input  logic       edge_fall,
  input  logic [1:0] src_sel,
  input  logic       baud_tick,
  input  logic       timer_match,
  input  logic       sclk_in,
  output logic       base_en,
  output logic       sclk_out,
  output logic       sclk_oe
);
  localparam int CTL_W = 5;

  logic [CTL_W-1:0] ctl, ctl_q;
  logic [2:0]       pin_sy;
  logic             sclk_q, base_q, pick;

  assign ctl = {async_mode, sclk_dir_in, edge_fall, src_sel};

  wire ctl_chg  = ctl != ctl_q;
  wire pin_rise = pin_sy[1] & ~pin_sy[2];
  wire pin_fall = ~pin_sy[1] & pin_sy[2];
  wire sync_out = ~async_mode & ~sclk_dir_in;

  always_comb begin
    if (!async_mode)
      pick = sclk_dir_in ? (edge_fall ? pin_fall : pin_rise) : (baud_tick & ~sclk_q);
    else
      case (src_sel)
        2'b00:   pick = baud_tick;
        2'b01:   pick = 1'b1;
        2'b10:   pick = timer_match;
        default: pick = pin_rise;
      endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_sy <= {3{sclk_in}};
      ctl_q  <= ctl;
      sclk_q <= 1'b1;
      base_q <= 1'b0;
    end else begin
      pin_sy <= {pin_sy[1:0], sclk_in};
      ctl_q  <= ctl;
      base_q <= pick & ~ctl_chg;
      sclk_q <= (sync_out & ~ctl_chg) ? (sclk_q ^ baud_tick) : 1'b1;
    end
  end

  assign base_en  = base_q;
  assign sclk_out = sclk_q;
  assign sclk_oe  = sync_out;
endmodule

// File: rtl/serial_baseclk_gen_chk.sv
module serial_baseclk_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       async_mode,
  input logic       sclk_dir_in,
  input logic       edge_fall,
  input logic [1:0] src_sel,
  input logic       baud_tick,
  input logic       timer_match,
  input logic       base_en,
  input logic       sclk_out
);
  logic [4:0] ctl;
  assign ctl = {async_mode, sclk_dir_in, edge_fall, src_sel};
  wire out_mode = !async_mode && !sclk_dir_in;

  p_div_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode && ctl == $past(ctl) && baud_tick && !sclk_out) |=> (base_en && sclk_out));

  p_every_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (async_mode && src_sel == 2'b01 && ctl == $past(ctl)) |=> base_en);

  p_timer_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (async_mode && src_sel == 2'b10 && ctl == $past(ctl)) |=> (base_en == $past(timer_match)));

  p_idle_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_mode |=> sclk_out);

  p_no_stale_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl != $past(ctl)) |=> !base_en);
endmodule

bind serial_baseclk_gen serial_baseclk_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .async_mode(async_mode), .sclk_dir_in(sclk_dir_in),
  .edge_fall(edge_fall), .src_sel(src_sel), .baud_tick(baud_tick),
  .timer_match(timer_match), .base_en(base_en), .sclk_out(sclk_out)
);

// File: tb/tb_serial_baseclk_gen.sv
module tb_serial_baseclk_gen;
  logic clk = 0, rst_n = 0;
  logic async_mode = 0, sclk_dir_in = 0, edge_fall = 0;
  logic [1:0] src_sel = 2'b00;
  logic baud_tick = 0, timer_match = 0, sclk_in = 0;
  logic base_en, sclk_out, sclk_oe;

  serial_baseclk_gen dut (
    .clk(clk), .rst_n(rst_n), .async_mode(async_mode), .sclk_dir_in(sclk_dir_in),
    .edge_fall(edge_fall), .src_sel(src_sel), .baud_tick(baud_tick),
    .timer_match(timer_match), .sclk_in(sclk_in), .base_en(base_en),
    .sclk_out(sclk_out), .sclk_oe(sclk_oe)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  int exp_q[$];
  string req_q[$];
  bit mon_on = 0;
  bit done = 0;

  task automatic chk(bit ok, string r, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", r, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int e;
    string r;
    if (rst_n && mon_on && base_en) begin
      if (exp_q.size() == 0) chk(0, "R10", "unexpected pulse at cycle", cyc, -1);
      else begin
        e = exp_q.pop_front();
        r = req_q.pop_front();
        chk(e == cyc, r, "pulse cycle", cyc, e);
      end
    end
  end

  task automatic cfg(bit am, bit dir, bit ef, bit [1:0] s);
    @(negedge clk);
    async_mode = am; sclk_dir_in = dir; edge_fall = ef; src_sel = s;
    repeat (2) @(negedge clk);
  endtask

  task automatic strobe(int which, bit exp, string r);
    @(negedge clk);
    if (which == 0) baud_tick = 1; else timer_match = 1;
    if (exp) begin exp_q.push_back(cyc + 1); req_q.push_back(r); end
    @(negedge clk);
    baud_tick = 0; timer_match = 0;
    if (!exp) chk(base_en == 0, r, "base_en after unselected strobe", base_en, 0);
    @(negedge clk);
  endtask

  task automatic pin(bit v, bit exp, string r);
    @(negedge clk);
    sclk_in = v;
    if (exp) begin exp_q.push_back(cyc + 3); req_q.push_back(r); end
    repeat (3) @(negedge clk);
    if (!exp) chk(base_en == 0, r, "base_en after ignored edge", base_en, 0);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(base_en == 0, "R8", "base_en in reset", base_en, 0);
    chk(sclk_out == 1, "R8", "sclk_out in reset", sclk_out, 1);
    rst_n = 1;
    mon_on = 1;
    @(negedge clk);
    chk(sclk_out == 1, "R8", "sclk_out after reset", sclk_out, 1);

    cfg(0, 0, 0, 2'b00);
    chk(sclk_oe == 1, "R2", "sclk_oe output mode", sclk_oe, 1);
    for (int i = 0; i < 6; i++) begin
      strobe(0, i % 2 == 1, "R1");
      chk(sclk_out == (i % 2 == 1), "R2", "sclk_out after tick", sclk_out, i % 2 == 1);
    end
    strobe(0, 0, "R1");
    chk(sclk_out == 0, "R2", "sclk_out low mid period", sclk_out, 0);
    cfg(1, 0, 0, 2'b00);
    chk(sclk_out == 1, "R8", "sclk_out leaving output mode", sclk_out, 1);
    chk(sclk_oe == 0, "R2", "sclk_oe in UART mode", sclk_oe, 0);
    cfg(0, 0, 0, 2'b00);
    strobe(0, 0, "R9");
    chk(sclk_out == 0, "R9", "divider restarted high", sclk_out, 0);
    strobe(0, 1, "R9");

    cfg(0, 1, 0, 2'b00);
    chk(sclk_oe == 0, "R2", "sclk_oe input mode", sclk_oe, 0);
    pin(1, 1, "R3");
    pin(0, 0, "R3");
    strobe(0, 0, "R10");
    chk(sclk_out == 1, "R10", "sclk_out with tick in input mode", sclk_out, 1);
    pin(1, 1, "R3");
    pin(0, 0, "R3");

    cfg(0, 1, 1, 2'b00);
    pin(1, 0, "R3");
    pin(0, 1, "R3");

    cfg(1, 0, 0, 2'b00);
    strobe(0, 1, "R4");
    strobe(0, 1, "R4");
    strobe(1, 0, "R10");
    pin(1, 0, "R10");
    pin(0, 0, "R10");

    cfg(1, 0, 0, 2'b10);
    strobe(1, 1, "R6");
    strobe(0, 0, "R10");
    strobe(1, 1, "R6");

    cfg(1, 0, 0, 2'b11);
    pin(1, 1, "R7");
    pin(0, 0, "R7");
    strobe(0, 0, "R10");
    pin(1, 1, "R7");
    pin(0, 0, "R7");

    mon_on = 0;
    @(negedge clk);
    src_sel = 2'b01;
    repeat (2) @(negedge clk);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      n += int'(base_en);
      @(negedge clk);
    end
    chk(n == 10, "R5", "pulses in 10 cycles", n, 10);
    src_sel = 2'b10;
    @(negedge clk);
    chk(base_en == 0, "R9", "base_en after leaving every-cycle source", base_en, 0);
    @(negedge clk);
    chk(base_en == 0, "R10", "base_en timer idle", base_en, 0);
    mon_on = 1;

    @(negedge clk);
    src_sel = 2'b00; baud_tick = 1;
    @(negedge clk);
    baud_tick = 0;
    chk(base_en == 0, "R9", "tick coincident with change", base_en, 0);
    @(negedge clk);
    strobe(0, 1, "R4");

    repeat (4) @(negedge clk);
    while (exp_q.size() > 0) chk(0, req_q.pop_front(), "missing pulse", -1, exp_q.pop_front());
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule